// File: doc/BRIEF.md
# Memory-Operand Address Form Decoder

This block turns the addressing byte that follows an opcode, plus an optional scaled-index byte, into a compact operand descriptor. The descriptor tells the rest of the decode pipeline several things: whether the operand is a register or memory; which base and index registers take part; the index scale factor; and how many displacement bytes come next in the instruction stream. It also says whether a scaled-index byte is still needed to complete the form. The caller selects 16-bit or 32-bit addressing with one input. A second input marks instructions that accept only a memory operand, such as far-pointer loads.

The decode itself is combinational. Its result is captured in one output register with a valid flag, so a descriptor appears exactly one clock after it is presented. While no new input is valid, the last descriptor is held. Register codes are 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI and 7 DI. Operand kind codes are 0 register, 1 indirect with base, 2 indirect without base and 3 direct address. The scale factor is reported as a 4-bit value, 1 shifted left by the 2-bit scale field.

Top module: `modrm_decode`

## Requirements
- R1: out_valid equals in_valid delayed by one clock. When in_valid is low, every descriptor output keeps its previous value.
- R2: reg_sel equals bits 5:3 of the addressing byte captured in the previous cycle.
- R3: When bits 7:6 (the mode field) are 3, the result has kind 0, base_reg equal to bits 2:0 (rm), no index, zero displacement bytes and need_sib 0.
- R4: illegal is 1 exactly when mem_only is 1 and the mode is 3. mem_only changes no other output.
- R5: In 16-bit mode, mode 0 with rm 6 gives kind 3 (direct), base_reg 0, no index and 2 displacement bytes.
- R6: In 16-bit mode, rm 0 to 3 give kind 1 with base/index pairs BX/SI, BX/DI, BP/SI and BP/DI in that order.
- R7: In 16-bit mode, rm 4, 5 and 7 give kind 2 with base_reg 0 and index SI, DI and BX respectively. rm 6 outside mode 0 gives kind 1, base BP and no index.
- R8: Displacement bytes are 0, 1 and the address size (2 in 16-bit mode, 4 in 32-bit mode) for modes 0, 1 and 2, except where R5, R9 or R11 say otherwise.
- R9: In 32-bit mode with rm other than 4, the result has kind 1 with base rm and no index. The exception is mode 0 with rm 5, which gives kind 3, base 0 and 4 displacement bytes.
- R10: In 32-bit mode, rm 4 outside mode 3 sets need_sib. With sib_valid, scale_factor is 1 shifted left by sib bits 7:6, index_reg is sib bits 5:3 with index_en cleared when that field is 4, and base_reg is sib bits 2:0. Without sib_valid, base_reg is 4, there is no index and scale_factor is 1.
- R11: In 32-bit mode, mode 0 with rm 4 and a valid sib whose base field is 5 gives kind 2, base_reg 0 and 4 displacement bytes.
- R12: While reset is asserted, out_valid, need_sib, illegal, opnd_kind and disp_bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Addressing byte is presented this cycle |
| modrm_byte | input | 8 | Mode, reg and rm fields |
| sib_byte | input | 8 | Scale, index and base fields |
| sib_valid | input | 1 | sib_byte holds a real byte |
| addr32 | input | 1 | 1 selects 32-bit addressing |
| mem_only | input | 1 | Instruction requires a memory operand |
| out_valid | output | 1 | Descriptor outputs are new this cycle |
| reg_sel | output | 3 | Reg field |
| opnd_kind | output | 2 | Operand kind code |
| base_reg | output | 3 | Base register code |
| index_reg | output | 3 | Index register code |
| index_en | output | 1 | An index register takes part |
| scale_factor | output | 4 | Index multiplier |
| disp_bytes | output | 3 | Displacement byte count |
| need_sib | output | 1 | A scaled-index byte belongs to this form |
| illegal | output | 1 | Register operand where memory is required |

## Verification
The bench targets the places where the two addressing widths diverge. In 16-bit mode, rm 6 is direct only in mode 0, and a decoder that ignored the mode would lose the BP base in modes 1 and 2. In 32-bit mode, rm 5 in mode 0 is direct, and a confused table would report BP with no displacement. The scaled-index corner cases are index field 4 (no index) and base field 5 in mode 0 (no base, 4 displacement bytes). A design that got these wrong would report a phantom SP index or a zero-length displacement. Every addressing byte is swept in both widths, and each register-mode form is checked with and without the memory-only flag.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

  localparam int DISP_W = 3;

  typedef enum logic [1:0] {
    OPK_REG        = 2'd0,
    OPK_IND        = 2'd1,
    OPK_IND_NOBASE = 2'd2,
    OPK_DIRECT     = 2'd3
  } opnd_kind_e;

  localparam logic [2:0] RC_AX = 3'd0;
  localparam logic [2:0] RC_BX = 3'd3;
  localparam logic [2:0] RC_SP = 3'd4;
  localparam logic [2:0] RC_BP = 3'd5;
  localparam logic [2:0] RC_SI = 3'd6;
  localparam logic [2:0] RC_DI = 3'd7;

  typedef struct packed {
    opnd_kind_e          kind;
    logic [2:0]          base;
    logic [2:0]          index;
    logic                index_en;
    logic [1:0]          scale_log2;
    logic [DISP_W-1:0]   disp_bytes;
    logic                need_sib;
  } addr_form_t;

  // Multiplier for the index register, from the 2-bit scale field.
  function automatic logic [3:0] scale_to_factor(input logic [1:0] s);
    return 4'b0001 << s;
  endfunction

  // Displacement length chosen by the mode field (modes 0..2).
  function automatic logic [DISP_W-1:0] disp_for_mode(input logic [1:0] mode,
                                                      input logic [DISP_W-1:0] wide);
    case (mode)
      2'd0:    return '0;
      2'd1:    return DISP_W'(1);
      default: return wide;
    endcase
  endfunction

endpackage

// File: rtl/modrm_form16.sv
module modrm_form16
  import modrm_pkg::*;
#(
  parameter int DISP16_BYTES = 2
) (
  input  logic [1:0]  mode,
  input  logic [2:0]  rm,
  output addr_form_t  form
);
  localparam logic [DISP_W-1:0] WIDE = DISP_W'(DISP16_BYTES);

  logic direct_hit;
  assign direct_hit = (mode == 2'd0) && (rm == 3'd6);

  always_comb begin
    form            = '0;
    form.kind       = OPK_IND;
    form.disp_bytes = disp_for_mode(mode, WIDE);
    form.index_en   = 1'b1;
    case (rm)
      3'd0: begin form.base = RC_BX; form.index = RC_SI; end
      3'd1: begin form.base = RC_BX; form.index = RC_DI; end
      3'd2: begin form.base = RC_BP; form.index = RC_SI; end
      3'd3: begin form.base = RC_BP; form.index = RC_DI; end
      3'd4: begin form.kind = OPK_IND_NOBASE; form.index = RC_SI; end
      3'd5: begin form.kind = OPK_IND_NOBASE; form.index = RC_DI; end
      3'd6: begin form.base = RC_BP; form.index_en = 1'b0; end
      default: begin form.kind = OPK_IND_NOBASE; form.index = RC_BX; end
    endcase
    if (direct_hit) begin
      form            = '0;
      form.kind       = OPK_DIRECT;
      form.disp_bytes = WIDE;
    end
  end
endmodule

// File: rtl/modrm_form32.sv
module modrm_form32
  import modrm_pkg::*;
#(
  parameter int DISP32_BYTES = 4
) (
  input  logic [1:0]  mode,
  input  logic [2:0]  rm,
  input  logic        sib_valid,
  input  logic [7:0]  sib_byte,
  output addr_form_t  form
);
  localparam logic [DISP_W-1:0] WIDE = DISP32_BYTES[DISP_W-1:0];

  logic       direct_hit, sib_escape, sib_nobase;
  logic [1:0] sib_scale;
  logic [2:0] sib_index, sib_base;

  assign sib_scale  = sib_byte[7:6];
  assign sib_index  = sib_byte[5:3];
  assign sib_base   = sib_byte[2:0];
  assign direct_hit = (mode == 2'd0) && (rm == 3'd5);
  assign sib_escape = (rm == RC_SP);
  assign sib_nobase = sib_escape && sib_valid && (mode == 2'd0) && (sib_base == RC_BP);

  always_comb begin
    form            = '0;
    form.kind       = OPK_IND;
    form.base       = rm;
    form.disp_bytes = disp_for_mode(mode, WIDE);
    if (direct_hit) begin
      form.kind       = OPK_DIRECT;
      form.base       = RC_AX;
      form.disp_bytes = WIDE;
    end else if (sib_escape) begin
      form.need_sib = 1'b1;
      if (sib_valid) begin
        form.scale_log2 = sib_scale;
        form.index      = sib_index;
        form.index_en   = (sib_index != RC_SP);
        form.base       = sib_base;
      end
      if (sib_nobase) begin
        form.kind       = OPK_IND_NOBASE;
        form.base       = RC_AX;
        form.disp_bytes = WIDE;
      end
    end
  end
endmodule

// File: rtl/modrm_decode.sv
module modrm_decode
  import modrm_pkg::*;
#(
  parameter int ENABLE_32    = 1,
  parameter int DISP16_BYTES = 2,
  parameter int DISP32_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  modrm_byte,
  input  logic [7:0]  sib_byte,
  input  logic        sib_valid,
  input  logic        addr32,
  input  logic        mem_only,
  output logic        out_valid,
  output logic [2:0]  reg_sel,
  output logic [1:0]  opnd_kind,
  output logic [2:0]  base_reg,
  output logic [2:0]  index_reg,
  output logic        index_en,
  output logic [3:0]  scale_factor,
  output logic [2:0]  disp_bytes,
  output logic        need_sib,
  output logic        illegal
);
  logic [1:0] mode;
  logic [2:0] regf, rm;
  assign mode = modrm_byte[7:6];
  assign regf = modrm_byte[5:3];
  assign rm   = modrm_byte[2:0];

  addr_form_t f16, f32, sel, q;
  logic       reg_form_hit, illegal_c, use32;
  logic [2:0] reg_q;
  logic       illegal_q;

  assign reg_form_hit = (mode == 2'd3);
  assign illegal_c    = reg_form_hit && mem_only;

  modrm_form16 #(.DISP16_BYTES(DISP16_BYTES)) u_form16 (
    .mode (mode),
    .rm   (rm),
    .form (f16)
  );

  generate
    if (ENABLE_32 != 0) begin : g_a32
      modrm_form32 #(.DISP32_BYTES(DISP32_BYTES)) u_form32 (
        .mode      (mode),
        .rm        (rm),
        .sib_valid (sib_valid),
        .sib_byte  (sib_byte),
        .form      (f32)
      );
      assign use32 = addr32;
    end else begin : g_no32
      assign f32   = f16;
      assign use32 = 1'b0;
    end
  endgenerate

  always_comb begin
    sel = use32 ? f32 : f16;
    if (reg_form_hit) begin
      sel      = '0;
      sel.kind = OPK_REG;
      sel.base = rm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
      reg_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        q         <= sel;
        reg_q     <= regf;
        illegal_q <= illegal_c;
      end
    end
  end

  assign reg_sel      = reg_q;
  assign opnd_kind    = q.kind;
  assign base_reg     = q.base;
  assign index_reg    = q.index;
  assign index_en     = q.index_en;
  assign scale_factor = scale_to_factor(q.scale_log2);
  assign disp_bytes   = q.disp_bytes;
  assign need_sib     = q.need_sib;
  assign illegal      = illegal_q;
endmodule

// File: rtl/modrm_decode_chk.sv
module modrm_decode_chk #(
  parameter int ENABLE_32    = 1,
  parameter int DISP32_BYTES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] modrm_byte,
  input logic [7:0] sib_byte,
  input logic       sib_valid,
  input logic       addr32,
  input logic       out_valid,
  input logic [2:0] reg_sel,
  input logic [1:0] opnd_kind,
  input logic [2:0] base_reg,
  input logic       index_en,
  input logic [3:0] scale_factor,
  input logic [2:0] disp_bytes,
  input logic       need_sib,
  input logic       illegal
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(reg_sel) && $stable(opnd_kind) && $stable(base_reg) && $stable(disp_bytes));

  p_reg_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> reg_sel == $past(modrm_byte[5:3]));

  p_mod3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && modrm_byte[7:6] == 2'd3 |=>
      opnd_kind == 2'd0 && base_reg == $past(modrm_byte[2:0]) && !index_en && disp_bytes == 3'd0);

  p_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> opnd_kind == 2'd0);

  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && opnd_kind == 2'd3 |-> !index_en && !need_sib && disp_bytes != 3'd0);

  p_disp_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && modrm_byte[7:6] == 2'd1 |=> disp_bytes == 3'd1);

  p_scale_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(scale_factor) == 1);

  p_sib_nobase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ENABLE_32 != 0) && in_valid && addr32 && modrm_byte[7:6] == 2'd0 && modrm_byte[2:0] == 3'd4
      && sib_valid && sib_byte[2:0] == 3'd5 |=>
      opnd_kind == 2'd2 && base_reg == 3'd0 && disp_bytes == 3'(DISP32_BYTES));
endmodule

bind modrm_decode modrm_decode_chk #(.ENABLE_32(ENABLE_32), .DISP32_BYTES(DISP32_BYTES)) u_chk (.*);

// File: tb/tb_modrm_decode.sv
module tb_modrm_decode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] modrm_byte = '0;
  logic [7:0] sib_byte = '0;
  logic       sib_valid = 1'b0;
  logic       addr32 = 1'b0;
  logic       mem_only = 1'b0;
  logic       out_valid;
  logic [2:0] reg_sel, base_reg, index_reg, disp_bytes;
  logic [1:0] opnd_kind;
  logic       index_en, need_sib, illegal;
  logic [3:0] scale_factor;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  modrm_decode dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm_byte(modrm_byte),
    .sib_byte(sib_byte), .sib_valid(sib_valid), .addr32(addr32), .mem_only(mem_only),
    .out_valid(out_valid), .reg_sel(reg_sel), .opnd_kind(opnd_kind), .base_reg(base_reg),
    .index_reg(index_reg), .index_en(index_en), .scale_factor(scale_factor),
    .disp_bytes(disp_bytes), .need_sib(need_sib), .illegal(illegal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (modrm=%02h sib=%02h sv=%0b a32=%0b)",
               req, what, act, exp, modrm_byte, sib_byte, sib_valid, addr32);
    end
  endtask

  // Reference model restating the requirements.
  function automatic void model(input logic [7:0] m, input logic [7:0] s, input bit sv,
                                input bit a32, input bit mo, output int kind, output int base,
                                output int idx, output int ien, output int fac,
                                output int disp, output int nsib, output int ill,
                                output string tag);
    int md = int'(m[7:6]);
    int r  = int'(m[2:0]);
    kind = 1; base = 0; idx = 0; ien = 0; fac = 1; nsib = 0;
    ill  = (mo && md == 3) ? 1 : 0;
    disp = (md == 0) ? 0 : (md == 1) ? 1 : (a32 ? 4 : 2);
    if (md == 3) begin
      kind = 0; base = r; disp = 0; tag = "R3";
    end else if (!a32) begin
      tag = "R6";
      if (md == 0 && r == 6) begin kind = 3; disp = 2; tag = "R5"; end
      else begin
        ien = 1;
        if (r < 4) begin
          base = (r < 2) ? 3 : 5;
          idx  = (r[0]) ? 7 : 6;
        end else begin
          tag = "R7";
          if (r == 6) begin base = 5; ien = 0; end
          else begin kind = 2; idx = (r == 4) ? 6 : (r == 5) ? 7 : 3; end
        end
      end
    end else begin
      tag = "R9";
      if (md == 0 && r == 5) begin kind = 3; disp = 4; end
      else if (r == 4) begin
        tag = "R10"; nsib = 1; base = 4;
        if (sv) begin
          fac  = 1 << s[7:6];
          idx  = int'(s[5:3]);
          ien  = (idx != 4) ? 1 : 0;
          base = int'(s[2:0]);
          if (md == 0 && base == 5) begin kind = 2; base = 0; disp = 4; tag = "R11"; end
        end
      end else base = r;
    end
  endfunction

  task automatic run_one(input logic [7:0] m, input logic [7:0] s, input bit sv,
                         input bit a32, input bit mo);
    int kind, base, idx, ien, fac, disp, nsib, ill;
    string tag;
    model(m, s, sv, a32, mo, kind, base, idx, ien, fac, disp, nsib, ill, tag);
    modrm_byte = m; sib_byte = s; sib_valid = sv; addr32 = a32; mem_only = mo;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", int'(out_valid), 1);
    chk("R2", "reg_sel", int'(reg_sel), int'(m[5:3]));
    chk(tag, "kind", int'(opnd_kind), kind);
    chk(tag, "base", int'(base_reg), base);
    chk(tag, "index_en", int'(index_en), ien);
    if (ien != 0) chk(tag, "index", int'(index_reg), idx);
    chk("R10", "scale", int'(scale_factor), fac);
    chk("R8", "disp", int'(disp_bytes), disp);
    chk("R10", "need_sib", int'(need_sib), nsib);
    chk("R4", "illegal", int'(illegal), ill);
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk("R12", "out_valid", int'(out_valid), 0);
    chk("R12", "need_sib", int'(need_sib), 0);
    chk("R12", "illegal", int'(illegal), 0);
    chk("R12", "kind", int'(opnd_kind), 0);
    chk("R12", "disp", int'(disp_bytes), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners.
    run_one(8'h06, 8'h00, 1'b0, 1'b0, 1'b0);   // R5 direct
    run_one(8'h46, 8'h00, 1'b0, 1'b0, 1'b0);   // R7 BP base with disp8
    run_one(8'h86, 8'h00, 1'b0, 1'b0, 1'b0);   // R7 BP base with disp16
    run_one(8'hC1, 8'h00, 1'b0, 1'b0, 1'b1);   // R4 illegal register form
    run_one(8'h01, 8'h00, 1'b0, 1'b0, 1'b1);   // R4 mem_only without effect
    run_one(8'h05, 8'h00, 1'b0, 1'b1, 1'b0);   // R9 32-bit direct
    run_one(8'h04, 8'hC5, 1'b1, 1'b1, 1'b0);   // R11 no base, scale 8
    run_one(8'h44, 8'h25, 1'b1, 1'b1, 1'b0);   // R10 base BP kept with disp8
    run_one(8'h04, 8'h63, 1'b1, 1'b1, 1'b0);   // R10 index field 4 means no index
    run_one(8'h84, 8'h00, 1'b0, 1'b1, 1'b0);   // R10 escape without sib byte

    // R1 hold: no new input, outputs keep values.
    begin
      logic [2:0] keep_reg;
      logic [1:0] keep_kind;
      keep_reg  = reg_sel;
      keep_kind = opnd_kind;
      in_valid = 1'b0; modrm_byte = 8'hFF;
      @(negedge clk);
      chk("R1", "out_valid idle", int'(out_valid), 0);
      chk("R1", "reg_sel held", int'(reg_sel), int'(keep_reg));
      chk("R1", "kind held", int'(opnd_kind), int'(keep_kind));
    end

    // Sweep of every addressing byte in both widths.
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 256; b++) begin
        run_one(8'(b), 8'($urandom), 1'($urandom), 1'(w), 1'($urandom));
      end
    end

    // Constrained random with occasional idle cycles.
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 9) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid idle", int'(out_valid), 0);
      end
      run_one(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    in_valid = 1'b0;
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule